// File: doc/BRIEF.md
# Timing-Error Capture Register for a Multiplier Product

This block registers the 2m-bit product of an m-by-m multiplier and checks every bit for late arrival. Each bit has two samples. The main flop samples on the rising edge of the normal clock. A level-sensitive shadow latch samples again while a delayed copy of that clock is high, which gives a slow path more time to settle. If the two samples differ, the main flop caught a value before the path had settled. The bit is then marked as failed, and on the next clock edge the stored bit is overwritten with the late sample.

The per-bit mismatches are registered into an error vector and OR-reduced into one error flag. The flag tells the surrounding controller to run the operation again and tells the hold logic that a timing error occurred. A load enable freezes the register in cycles where the multiplier clock is gated. The delayed clock is produced outside the block. Re-execution is handled outside the block.

Top module: `razor_capture_reg`

## Requirements
- R1: A synchronous active-high reset clears `prod_q`, `err_bits` and `err_any` to zero.
- R2: On a rising `clk` edge with `load_en` = 1 and no pending mismatch, `prod_q` takes the value of `prod_d`.
- R3: On a rising `clk` edge with `load_en` = 0 and no pending mismatch, `prod_q` keeps its value.
- R4: In the cycle after a capture, the shadow latch follows `prod_d` while `dclk` is high and holds while `dclk` is low. A change on `prod_d` after `dclk` falls has no effect on the comparison.
- R5: Bit i of the mismatch vector is the XOR of main-flop bit i and shadow bit i. At the `clk` edge that ends the capture cycle, `err_bits` is loaded with this vector.
- R6: At the same edge, `err_any` is loaded with the OR of all mismatch bits. It is therefore valid one cycle after the capturing edge.
- R7: At that edge, every mismatching bit of `prod_q` is replaced by its shadow value, so `prod_q` then holds the late, settled product.
- R8: A repair edge takes priority over loading. `prod_d` is not captured at that edge even if `load_en` = 1, and the following cycle is not compared.
- R9: When the previous edge did not capture, no error is raised and the shadow latches stay frozen, even if `prod_d` changes while `dclk` is high.
- R10: The register width is `PROD_W` = 2·`OP_W` bits, one cell per product bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Normal clock; main flops and error registers |
| dclk | input | 1 | Delayed copy of `clk`; shadow latch enable |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Capture enable; low in gated multiplier cycles |
| prod_d | input | PROD_W | Combinational product from the multiplier |
| prod_q | output | PROD_W | Registered (and repaired) product |
| err_bits | output | PROD_W | Registered per-bit mismatch vector |
| err_any | output | 1 | Registered OR of the mismatch vector |

## Verification
The assertions assume that `dclk` is a copy of `clk` delayed by less than half a period. This means the shadow window opens after the capture edge and closes before the next edge. They also assume that `prod_d` is settled by the time `dclk` falls. The bench models a late path in two steps: it presents a wrong value at the capture edge, then switches to the settled value shortly after the edge and before `dclk` rises. It changes `prod_d` to unrelated data only after `dclk` has fallen. The mismatch masks are random and include the no-error case.

// File: rtl/razor_pkg.sv
package razor_pkg;
  localparam int unsigned DFLT_OP_W = 16;
  localparam int unsigned DFLT_PROD_W = 2 * DFLT_OP_W;
endpackage

// File: rtl/razor_bit_cell.sv
module razor_bit_cell (
  input  logic clk,
  input  logic dclk,
  input  logic rst,
  input  logic armed,
  input  logic load,
  input  logic repair,
  input  logic d,
  output logic q,
  output logic mis
);
  logic sh;

  // Shadow latch: open only in the cycle that follows a capture.
  always_latch begin
    if (rst) sh <= 1'b0;
    else if (dclk && armed) sh <= d;
  end

  assign mis = armed & (q ^ sh);

  // Main flop with repair mux; a repair edge freezes good bits.
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else if (repair) q <= mis ? sh : q;
    else if (load) q <= d;
  end

  assert_bit_repair_R7: assert property (@(posedge clk) disable iff (rst)
    (repair && mis) |=> (q != $past(q)));
  assert_bit_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (repair && !mis) |=> $stable(q));
endmodule

// File: rtl/razor_arm_ctl.sv
module razor_arm_ctl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic repair,
  output logic armed
);
  // armed marks the cycle after a real capture; only then is a compare valid.
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= load & ~repair;
  end

  assert_repair_disarms_R8: assert property (@(posedge clk) disable iff (rst)
    repair |=> !armed);
  assert_idle_disarms_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> !armed);
endmodule

// File: rtl/razor_err_reg.sv
module razor_err_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mis_vec,
  output logic         any_mis,
  output logic [W-1:0] err_bits,
  output logic         err_any
);
  assign any_mis = |mis_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_bits <= '0;
      err_any  <= 1'b0;
    end else begin
      err_bits <= mis_vec;
      err_any  <= any_mis;
    end
  end

  assert_flag_matches_bits_R6: assert property (@(posedge clk) disable iff (rst)
    !err_any |-> (err_bits == '0));
  assert_bits_imply_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (err_bits != '0) |-> err_any);
endmodule

// File: rtl/razor_capture_reg.sv
module razor_capture_reg #(
  parameter int unsigned OP_W   = razor_pkg::DFLT_OP_W,
  parameter int unsigned PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              dclk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [PROD_W-1:0] prod_d,
  output logic [PROD_W-1:0] prod_q,
  output logic [PROD_W-1:0] err_bits,
  output logic              err_any
);
  logic              armed;
  logic              any_mis;
  logic [PROD_W-1:0] mis_vec;

  razor_arm_ctl u_ctl (
    .clk(clk), .rst(rst), .load(load_en), .repair(any_mis), .armed(armed)
  );

  for (genvar i = 0; i < PROD_W; i++) begin : g_bit
    razor_bit_cell u_cell (
      .clk(clk), .dclk(dclk), .rst(rst), .armed(armed), .load(load_en),
      .repair(any_mis), .d(prod_d[i]), .q(prod_q[i]), .mis(mis_vec[i])
    );
  end

  razor_err_reg #(.W(PROD_W)) u_err (
    .clk(clk), .rst(rst), .mis_vec(mis_vec), .any_mis(any_mis),
    .err_bits(err_bits), .err_any(err_any)
  );

  initial assert_width_R10: assert (PROD_W == 2 * OP_W);

  assert_no_err_unarmed_R9: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !any_mis);
  assert_err_registered_R6: assert property (@(posedge clk) disable iff (rst)
    any_mis |=> err_any);
  assert_no_err_registered_R6: assert property (@(posedge clk) disable iff (rst)
    !any_mis |=> !err_any);
  assert_bits_registered_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_bits == $past(mis_vec)));
  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && !any_mis) |=> (prod_q == $past(prod_d)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !any_mis) |=> $stable(prod_q));
  assert_repair_clears_R7: assert property (@(posedge clk) disable iff (rst)
    any_mis |=> (prod_q == ($past(prod_q) ^ $past(mis_vec))));
endmodule

// File: tb/razor_capture_reg_test.sv
module razor_capture_reg_test;
  localparam int unsigned OP_W = 16;
  localparam int unsigned PW = 2 * OP_W;

  logic clk = 1'b0, dclk = 1'b0, rst = 1'b1, load_en = 1'b0;
  logic [PW-1:0] prod_d = '0;
  logic [PW-1:0] prod_q, err_bits;
  logic err_any;
  int total = 0, bad = 0;
  logic [PW-1:0] exp_q = '0;

  razor_capture_reg #(.OP_W(OP_W)) uut (
    .clk(clk), .dclk(dclk), .rst(rst), .load_en(load_en), .prod_d(prod_d),
    .prod_q(prod_q), .err_bits(err_bits), .err_any(err_any)
  );

  always #5 clk = ~clk;
  always @(clk) dclk <= #3 clk;

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] rnd_word();
    return PW'($urandom());
  endfunction

  // Entered and left at posedge+9 (dclk low, clk low).
  task automatic do_op(input logic [PW-1:0] w, input logic [PW-1:0] c,
                       input logic lp, input logic [PW-1:0] x);
    logic [PW-1:0] m;
    m = w ^ c;
    load_en = 1'b1; prod_d = w;
    @(posedge clk); #1;
    prod_d = c;                       // settles before dclk rises
    #1;
    chk("R2 capture", prod_q, w);
    chk("R6 no flag after capture", {{(PW-1){1'b0}}, err_any}, '0);
    #7;
    load_en = lp; prod_d = x;         // after dclk fell: R4 shadow holds
    @(posedge clk); #2;
    chk("R5 err_bits", err_bits, m);
    chk("R6 err_any", {{(PW-1){1'b0}}, err_any}, {{(PW-1){1'b0}}, (m != '0)});
    if (m != '0) exp_q = c;           // R7 repair, R8 load ignored
    else if (lp) exp_q = x;           // R2
    else exp_q = w;                   // R3
    chk((m != '0) ? "R7 R8 repaired" : (lp ? "R2 capture" : "R3 hold"), prod_q, exp_q);
    #7;
  endtask

  initial begin : watchdog
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [PW-1:0] c, w, held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 prod_q reset", prod_q, '0);
    chk("R1 err_bits reset", err_bits, '0);
    chk("R1 err_any reset", {{(PW-1){1'b0}}, err_any}, '0);
    #7; rst = 1'b0;
    @(posedge clk); #9;

    // Directed corners
    do_op('0, '1, 1'b0, '0);                           // every bit late
    do_op('1, '1, 1'b1, 32'h0000_00ff);                // clean, back-to-back capture
    do_op(32'h8000_0001, 32'h0000_0001, 1'b1, '1);     // top bit late, load ignored R8
    do_op(32'h1234_5678, 32'h1234_5678, 1'b0, '0);    // clean, hold R3

    // R9: no capture, prod_d wiggles through the dclk window
    held = prod_q;
    load_en = 1'b0; prod_d = rnd_word();
    @(posedge clk); #1;
    prod_d = rnd_word();
    #4; prod_d = rnd_word();
    #5;
    @(posedge clk); #2;
    chk("R9 no error when idle", {{(PW-1){1'b0}}, err_any}, '0);
    chk("R9 err_bits idle", err_bits, '0);
    chk("R9 prod held idle", prod_q, held);
    #7;

    // Random mix
    for (int n = 0; n < 400; n++) begin
      c = rnd_word();
      case ($urandom_range(0, 3))
        0: w = c;
        1: w = c ^ (PW'(1) << $urandom_range(0, PW - 1));
        default: w = c ^ (rnd_word() & rnd_word() & rnd_word());
      endcase
      do_op(w, c, 1'($urandom_range(0, 1)), rnd_word());
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule